// File: doc/BRIEF.md
# Encoded-Edge to Plain Signal Converter

The block turns a signal carried in an edge-offset encoding into an ordinary one-bit signal. Each reference clock cycle the encoded word gives the level at the start of the cycle and up to two transitions. Each transition is placed at a quantized offset inside that cycle. Before the conversion, an optional filter removes pulses that are narrower than a programmable minimum width. A pulse is the span between two successive transitions, and it may lie inside one cycle or cross a cycle boundary. The filtered word is also brought out in the same encoding, so later logic can use it as it is.

The filter delays every word by one reference cycle. This lets it compare the last surviving edge of a cycle with the first edge of the next cycle. When the pair is too narrow, both edges are removed and the level simply carries on. The plain output presents the final level of each filtered cycle. A build parameter selects when that level appears: combinationally at offset zero, at the next falling reference edge, or at the next rising reference edge.

Top module: `enc_edge_converter`

## Requirements
- R1: An encoded word is `{start_level, edge_count[1:0], first_offset[OFS_W-1:0], second_offset[OFS_W-1:0]}`, with the start level in the top bit. The edge count is 0, 1 or 2 and never 3. With two edges, first_offset <= second_offset. Each edge toggles the level, and a word with one edge uses only first_offset.
- R2: A word presented before rising edge k appears on `enc_filt` after rising edge k+1. With the filter disabled, the word comes out unchanged.
- R3: With the filter enabled, a two-edge word whose second_offset minus first_offset is below `min_width` loses both edges, so its edge count becomes 0. A zero-width pulse is therefore removed whenever `min_width` >= 1.
- R4: With the filter enabled, the pulse between the last surviving edge L of one cycle and the first edge F of the next has width 2^OFS_W - L + F. If that width is below `min_width`, both edges are removed. The later word's start level inverts, and any edge that remains in it is not judged against its own predecessor again.
- R5: A pulse whose width is at least `min_width` keeps both edges, and `min_width` = 0 keeps every edge.
- R6: Offset fields of `enc_filt` that no longer carry an edge read zero. In offset-zero mode, `plain_out` equals start_level XOR edge_count[0] of the current `enc_filt` word.
- R7: In falling-edge mode, `plain_out` takes the final level of the current `enc_filt` word at the next falling reference edge.
- R8: In rising-edge mode, `plain_out` takes the final level of the current `enc_filt` word at the next rising reference edge.
- R9: A synchronous active-low reset sets `enc_filt` and `plain_out` to zero, sets the stored previous level to zero and discards any carried edge. An edge before reset is never paired with one after it.
- R10: Given a continuous input, the start level of each `enc_filt` word equals the final level of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_in | input | 2*OFS_W+3 | Encoded input word for the current cycle |
| filt_en | input | 1 | Enables minimum pulse width filtering |
| min_width | input | OFS_W+1 | Minimum pulse width in offset steps |
| enc_filt | output | 2*OFS_W+3 | Filtered encoded word, one cycle behind |
| plain_out | output | 1 | Plain level at the selected timing point |

## Verification
The hardest case to reach is a narrow pulse that straddles a cycle boundary. It gets harder when it interacts with a second pulse inside the following cycle, or with an edge that was left in the delay stage just before a reset. The stimulus sweeps every pair of one-edge words across a boundary, covering both sides of two minimum-width thresholds. It then adds hand-built chains in which a cross-boundary drop leaves a single edge behind. It also loads an edge into the delay stage, resets, and starts again with an edge at offset zero.

// File: rtl/edge_cvt_pkg.sv
// Shared definitions for the encoded-edge converter.
// Assumes nothing beyond being compiled ahead of the converter modules.
package edge_cvt_pkg;

    // Timing point at which the plain output presents a cycle's final level
    typedef enum logic [1:0] {
        SAMPLE_AT_ZERO = 2'd0,
        SAMPLE_AT_FALL = 2'd1,
        SAMPLE_AT_RISE = 2'd2
    } sample_pt_e;

    localparam int EDGE_CNT_W = 2;
    localparam int MAX_EDGES  = 2;

endpackage

// File: rtl/enc_pulse_filter.sv
// Minimum pulse width filter working on encoded words.
// Holds one word so that a pulse crossing a cycle boundary can be judged.
// Judges the cross-boundary pair first, then an in-cycle pair.
// Assumes legal, level-continuous input words.
module enc_pulse_filter #(
    parameter int OFS_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               filt_en,
    input  logic [OFS_W:0]     min_width,
    input  logic [2*OFS_W+2:0] word_in,
    output logic [2*OFS_W+2:0] word_out
);
    import edge_cvt_pkg::*;

    localparam int WD     = 2*OFS_W + 3;
    localparam int MW_W   = OFS_W + 1;
    localparam int CYC    = 1 << OFS_W;
    localparam int LVL    = WD - 1;
    localparam int CNT_LO = 2*OFS_W;
    localparam int A_LO   = OFS_W;

    logic                  c_lvl, h_lvl, nc_lvl, nh_lvl;
    logic [EDGE_CNT_W-1:0] c_cnt, h_cnt, nc_cnt, nh_cnt;
    logic [OFS_W-1:0]      c_a, c_b, h_a, h_b, nc_a, nc_b, nh_a, nh_b, h_last;
    logic [MW_W-1:0]       cross_w, in_w;
    logic                  cross_drop, in_drop;
    logic [WD-1:0]         hld_q, out_q;

    // Split the incoming and held words into fields
    always_comb begin
        c_lvl  = word_in[LVL];
        c_cnt  = word_in[CNT_LO +: EDGE_CNT_W];
        c_a    = word_in[A_LO +: OFS_W];
        c_b    = word_in[0 +: OFS_W];
        h_lvl  = hld_q[LVL];
        h_cnt  = hld_q[CNT_LO +: EDGE_CNT_W];
        h_a    = hld_q[A_LO +: OFS_W];
        h_b    = hld_q[0 +: OFS_W];
        h_last = (h_cnt == 2'd2) ? h_b : h_a;
    end

    // Measure the boundary pulse and the in-cycle pulse
    always_comb begin
        cross_w    = MW_W'(CYC) - MW_W'(h_last) + MW_W'(c_a);
        in_w       = MW_W'(c_b) - MW_W'(c_a);
        cross_drop = filt_en && (h_cnt != 2'd0) && (c_cnt != 2'd0) && (cross_w < min_width);
        in_drop    = filt_en && !cross_drop && (c_cnt == 2'd2) && (in_w < min_width);
    end

    // Remove dropped edges and clear offsets that no longer carry an edge
    always_comb begin
        nh_lvl = h_lvl;
        nh_cnt = h_cnt;
        nh_a   = h_a;
        nh_b   = h_b;
        nc_lvl = c_lvl;
        nc_cnt = c_cnt;
        nc_a   = c_a;
        nc_b   = c_b;
        if (cross_drop) begin
            nh_cnt = h_cnt - 2'd1;
            nc_lvl = ~c_lvl;
            if (c_cnt == 2'd2) begin
                nc_cnt = 2'd1;
                nc_a   = c_b;
            end else begin
                nc_cnt = 2'd0;
            end
        end else if (in_drop) begin
            nc_cnt = 2'd0;
        end
        if (nh_cnt < 2'd2) nh_b = '0;
        if (nh_cnt == 2'd0) nh_a = '0;
        if (nc_cnt < 2'd2) nc_b = '0;
        if (nc_cnt == 2'd0) nc_a = '0;
    end

    // Advance the held word and publish the word that is now final
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hld_q <= '0;
            out_q <= '0;
        end else begin
            hld_q <= {nc_lvl, nc_cnt, nc_a, nc_b};
            out_q <= {nh_lvl, nh_cnt, nh_a, nh_b};
        end
    end

    assign word_out = out_q;

    AST_IN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cnt != 2'd3) && ((c_cnt != 2'd2) || (c_a <= c_b))); // R1

    AST_NO_NARROW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_out[CNT_LO +: EDGE_CNT_W] == 2'd2) && $past(filt_en, 2) |->
        (MW_W'(word_out[0 +: OFS_W]) - MW_W'(word_out[A_LO +: OFS_W])) >= $past(min_width, 2)); // R3

    AST_OUT_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> word_out[LVL] == $past(word_out[LVL] ^ word_out[CNT_LO])); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (word_out == '0)); // R9

endmodule

// File: rtl/enc_level_decode.sv
// Final level of one encoded cycle: start level toggled once per edge.
// Assumes a legal edge count of 0, 1 or 2.
module enc_level_decode #(
    parameter int OFS_W = 4
) (
    input  logic [2*OFS_W+2:0] word,
    output logic               final_lvl
);
    localparam int WD     = 2*OFS_W + 3;
    localparam int CNT_LO = 2*OFS_W;

    // An odd edge count flips the start level
    always_comb final_lvl = word[WD-1] ^ word[CNT_LO];

endmodule

// File: rtl/enc_level_sampler.sv
// Presents a level at the chosen timing point of the reference clock.
// Offset-zero passes it straight through; the other points register it.
// Assumes rst_n is synchronous to clk.
module enc_level_sampler
    import edge_cvt_pkg::*;
#(
    parameter sample_pt_e SAMPLE_PT = SAMPLE_AT_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic plain_out
);
    generate
        if (SAMPLE_PT == SAMPLE_AT_ZERO) begin : g_zero
            // Present the level within the same cycle
            assign plain_out = lvl_in;
        end else if (SAMPLE_PT == SAMPLE_AT_FALL) begin : g_fall
            logic lvl_q;
            // Capture the level on the falling reference edge
            always_ff @(negedge clk) begin
                if (!rst_n) lvl_q <= 1'b0;
                else        lvl_q <= lvl_in;
            end
            assign plain_out = lvl_q;
        end else begin : g_rise
            logic lvl_q;
            // Capture the level on the next rising reference edge
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q <= 1'b0;
                else        lvl_q <= lvl_in;
            end
            assign plain_out = lvl_q;
        end
    endgenerate

endmodule

// File: rtl/enc_edge_converter.sv
// Encoded-edge to plain signal converter: filters narrow pulses in the
// encoded domain, then presents each cycle's final level at the timing
// point chosen by SAMPLE_PT. Assumes a level-continuous input stream.
module enc_edge_converter
    import edge_cvt_pkg::*;
#(
    parameter int         OFS_W     = 4,
    parameter sample_pt_e SAMPLE_PT = SAMPLE_AT_RISE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*OFS_W+2:0] enc_in,
    input  logic               filt_en,
    input  logic [OFS_W:0]     min_width,
    output logic [2*OFS_W+2:0] enc_filt,
    output logic               plain_out
);
    localparam int WD     = 2*OFS_W + 3;
    localparam int CNT_LO = 2*OFS_W;

    logic filt_final;

    enc_pulse_filter #(.OFS_W(OFS_W)) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_en   (filt_en),
        .min_width (min_width),
        .word_in   (enc_in),
        .word_out  (enc_filt)
    );

    enc_level_decode #(.OFS_W(OFS_W)) u_decode (
        .word      (enc_filt),
        .final_lvl (filt_final)
    );

    enc_level_sampler #(.SAMPLE_PT(SAMPLE_PT)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (filt_final),
        .plain_out (plain_out)
    );

    generate
        if (SAMPLE_PT == SAMPLE_AT_ZERO) begin : g_chk_zero
            AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
                plain_out == (enc_filt[WD-1] ^ enc_filt[CNT_LO])); // R6
        end else if (SAMPLE_PT == SAMPLE_AT_FALL) begin : g_chk_fall
            AST_FALL_FOLLOWS: assert property (@(negedge clk) disable iff (!rst_n)
                rst_n |=> plain_out == $past(enc_filt[WD-1] ^ enc_filt[CNT_LO])); // R7
        end else begin : g_chk_rise
            AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> plain_out == $past(enc_filt[WD-1] ^ enc_filt[CNT_LO])); // R8
        end
    endgenerate

endmodule

// File: tb/test_enc_edge_converter.sv
module test_enc_edge_converter;
    import edge_cvt_pkg::*;

    localparam int W  = 4;
    localparam int WD = 2*W + 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [WD-1:0] din   = '0;
    logic          en    = 1'b0;
    logic [W:0]    mw    = '0;
    logic [WD-1:0] f_r, f_z, f_f;
    logic          p_r, p_z, p_f;

    enc_edge_converter #(.OFS_W(W), .SAMPLE_PT(SAMPLE_AT_RISE)) i_enc_edge_converter (
        .clk(clk), .rst_n(rst_n), .enc_in(din), .filt_en(en), .min_width(mw),
        .enc_filt(f_r), .plain_out(p_r));
    enc_edge_converter #(.OFS_W(W), .SAMPLE_PT(SAMPLE_AT_ZERO)) i_enc_edge_converter_zero (
        .clk(clk), .rst_n(rst_n), .enc_in(din), .filt_en(en), .min_width(mw),
        .enc_filt(f_z), .plain_out(p_z));
    enc_edge_converter #(.OFS_W(W), .SAMPLE_PT(SAMPLE_AT_FALL)) i_enc_edge_converter_fall (
        .clk(clk), .rst_n(rst_n), .enc_in(din), .filt_en(en), .min_width(mw),
        .enc_filt(f_f), .plain_out(p_f));

    int n_chk  = 0;
    int n_fail = 0;

    logic [WD-1:0] pw [3];
    string         pr [3];
    bit            pv [3];
    logic          prev_fin = 1'b0;

    function automatic logic [WD-1:0] mk(bit l, int n, int a, int b);
        return {l, 2'(n), W'(a), W'(b)};
    endfunction

    function automatic logic fin(logic [WD-1:0] w);
        return w[WD-1] ^ w[2*W];
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 3; i++) begin
            pw[i] = '0;
            pr[i] = "R9";
            pv[i] = 1'b1;
        end
        prev_fin = 1'b0;
    endtask

    // One reference cycle: check the pipeline, then drive the next word
    task automatic cyc(logic [WD-1:0] w, logic [WD-1:0] expw, string req, bit v);
        @(posedge clk); #1;
        if (pv[1]) begin
            check(f_r == pw[1], {pr[1], " filtered word"}, 32'(f_r), 32'(pw[1]));
            check(f_z == pw[1] && f_f == pw[1], {pr[1], " filtered word (other modes)"},
                  32'(f_z), 32'(pw[1]));
            check(p_z == fin(pw[1]), "R6 offset-zero level", 32'(p_z), 32'(fin(pw[1])));
            check(f_r[WD-1] == prev_fin, "R10 start level continuity",
                  32'(f_r[WD-1]), 32'(prev_fin));
        end
        prev_fin = fin(f_r);
        if (pv[2]) begin
            check(p_r == fin(pw[2]), "R8 rising-edge level", 32'(p_r), 32'(fin(pw[2])));
            check(p_f == fin(pw[2]), "R7 level held until falling edge",
                  32'(p_f), 32'(fin(pw[2])));
        end
        @(negedge clk); #1;
        if (pv[1])
            check(p_f == fin(pw[1]), "R7 falling-edge level", 32'(p_f), 32'(fin(pw[1])));
        if (pv[2])
            check(p_r == fin(pw[2]), "R8 level held until rising edge",
                  32'(p_r), 32'(fin(pw[2])));
        pw[2] = pw[1]; pr[2] = pr[1]; pv[2] = pv[1];
        pw[1] = pw[0]; pr[1] = pr[0]; pv[1] = pv[0];
        pw[0] = expw;  pr[0] = req;   pv[0] = v;
        din = w;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0;
        din   = '0;
        repeat (3) @(negedge clk);
        #1;
        check(f_r == '0 && f_z == '0 && f_f == '0, "R9 reset clears filtered word",
              32'(f_r), 32'h0);
        check(!p_r && !p_z && !p_f, "R9 reset clears plain output",
              {29'd0, p_r, p_z, p_f}, 32'h0);
        rst_n = 1'b1;
        preload();
    endtask

    task automatic idles(int n);
        for (int i = 0; i < n; i++) cyc('0, '0, "R2 idle", 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stimulus
        logic [WD-1:0] w, w1, w2;
        bit            keep;
        int            wid;
        do_reset();

        // R3 R5 R2: every in-cycle pulse under several thresholds
        for (int cfg = 0; cfg < 4; cfg++) begin
            en = (cfg != 3);
            mw = (cfg == 0) ? 5'd0 : (cfg == 1) ? 5'd3 : 5'd7;
            idles(2);
            for (int a = 0; a < 16; a++) begin
                for (int b = a; b < 16; b++) begin
                    w    = mk(0, 2, a, b);
                    keep = !en || ((b - a) >= int'(mw));
                    cyc(w, keep ? w : '0, !en ? "R2 bypass" : keep ? "R5 kept" : "R3 dropped", 1'b1);
                    cyc('0, '0, "R2 idle", 1'b1);
                end
            end
        end

        // R4: every boundary-crossing pulse around two thresholds
        en = 1'b1;
        for (int t = 0; t < 2; t++) begin
            mw = (t == 0) ? 5'd17 : 5'd20;
            idles(2);
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    w1   = mk(0, 1, x, 0);
                    w2   = mk(1, 1, y, 0);
                    wid  = 16 - x + y;
                    keep = wid >= int'(mw);
                    cyc(w1, keep ? w1 : '0, keep ? "R5 boundary kept" : "R4 boundary dropped", 1'b1);
                    cyc(w2, keep ? w2 : '0, keep ? "R5 boundary kept" : "R4 boundary dropped", 1'b1);
                    cyc('0, '0, "R2 idle", 1'b1);
                end
            end
        end

        // R4: boundary drop between two-edge words
        mw = 5'd5;
        idles(2);
        cyc(mk(0, 2, 2, 14), mk(0, 1, 2, 0), "R4 two-edge pair", 1'b1);
        cyc(mk(0, 2, 1, 9),  mk(1, 1, 9, 0), "R4 two-edge pair", 1'b1);
        cyc('0, '0, "R2 idle", 1'b1);
        // R4: the edge left after a boundary drop is not judged in-cycle
        cyc(mk(0, 1, 14, 0), '0,              "R4 leftover edge", 1'b1);
        cyc(mk(1, 2, 1, 3),  mk(0, 1, 3, 0),  "R4 leftover edge", 1'b1);
        cyc(mk(1, 1, 10, 0), mk(1, 1, 10, 0), "R4 leftover edge", 1'b1);
        idles(2);

        // R9: a carried edge is discarded by reset
        mw = 5'd4;
        cyc(mk(0, 1, 15, 0), '0, "", 1'b0);
        do_reset();
        cyc(mk(0, 1, 0, 0), mk(0, 1, 0, 0), "R9 no pairing across reset", 1'b1);
        cyc(mk(1, 1, 8, 0), mk(1, 1, 8, 0), "R9 no pairing across reset", 1'b1);
        idles(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule